// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two byte-wide timer/counters, called A and B, of the kind found beside a small 8-bit processor core. Each timer has a low count byte, a high count byte and a 5-bit control byte. The control byte holds a 2-bit mode, a run bit, a gate bit and a source bit. Each timer also has a sticky overflow flag. A timer advances on a count tick. The source bit picks the tick: either the shared cycle strobe or the timer's own external event pulse. When the gate bit is set, the timer counts only while its external interrupt pin is high.

The mode sets the shape of the counter chain:
- Mode 0 is a 13-bit count: a 5-bit prescaler in the low byte drives the 8-bit high byte.
- Mode 1 is a 16-bit count.
- Mode 2 is an 8-bit count in the low byte, reloaded from the high byte.
- Mode 3 applies to timer A only. It splits A into two free 8-bit counters. The low half stays A's own. The high half runs on the cycle strobe under B's run bit and reports its wrap through B's flag. While A is in mode 3, B keeps its count but its own wraps no longer set B's flag.
- B in mode 3 simply holds its count.

Software reaches the block through a plain register port. A single-cycle write strobe is taken in the cycle it is asserted, with no back-pressure. The read port is combinational. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `mcu_timer_pair`

## Requirements
- R1: A synchronous reset clears all four count bytes, both control bytes and both flags. The control value 0 means mode 0, stopped, ungated and cycle-strobe source.
- R2: A timer advances only when three things hold together: its tick is present, its run bit (control bit 2) is 1, and either its gate bit (control bit 3) is 0 or its pin is high. The tick is the cycle strobe when source bit 4 is 0 and the timer's event input when it is 1. With the run bit clear, no count byte changes on a tick.
- R3: In mode 0 the low byte is incremented. If the result exceeds 0x1F, the low byte keeps only its five lowest bits and the high byte increments. For example, 0x1F becomes 0x00 and 0x25 becomes 0x06, each with a high-byte step.
- R4: In mode 0 the timer's flag is set when the high byte steps from 0xFF to 0x00.
- R5: In mode 1 the two bytes form one 16-bit counter, with high as the upper byte. The high byte steps only when the low byte wraps. The flag is set when 0xFFFF wraps to 0x0000.
- R6: In mode 2 only the low byte counts. On a step from 0xFF it loads the high byte's value and sets the flag. The high byte is left unchanged.
- R7: In mode 3, A's low byte is an independent 8-bit counter under A's own enable. Its wrap from 0xFF sets A's flag.
- R8: In mode 3, A's high byte steps on each cycle strobe while B's run bit is 1, and its wrap sets B's flag. While A is in mode 3, B's own wraps do not set B's flag.
- R9: When B is in mode 3, its count bytes hold. Only bus writes change them.
- R10: A bus write to a count byte always takes effect. In modes 0 to 2 it cancels that timer's whole count step in the same cycle, including any reload or flag set. In A's mode 3, it cancels only the step of the half that is written.
- R11: A flag stays at 1 until one of two things clears it: its acknowledge input, or a write to address 6 with a 1 in the flag's bit (bit 0 for A, bit 1 for B). A set in the same cycle wins over a clear.
- R12: Register addresses are: 0 = A low, 1 = A high, 2 = B low, 3 = B high, 4 = A control, 5 = B control, 6 = flags. A control write keeps data bits 4:0. Unused read bits and address 7 read 0, and writes to address 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_tick | input | 1 | Shared cycle strobe |
| ev_a | input | 1 | External event pulse for timer A |
| ev_b | input | 1 | External event pulse for timer B |
| pin_a | input | 1 | Gate pin level for timer A |
| pin_b | input | 1 | Gate pin level for timer B |
| ack_a | input | 1 | Clears A's flag |
| ack_b | input | 1 | Clears B's flag |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 8 | Read data, combinational |
| ovf_a | output | 1 | Timer A overflow flag |
| ovf_b | output | 1 | Timer B overflow flag |

## Verification
The bound checker watches several rules on every cycle:
- reset values;
- the frozen count while A is stopped outside split mode;
- the mode-2 reload source and the mode-1 wrap flag;
- a written low byte winning over a tick;
- flag persistence without a clear;
- B's hold in mode 3.

Other behaviours need sequences that only the bench scenarios build:
- the mode-0 prescaler carry, including its quirk with high bits already set in the low byte;
- the mode-3 hand-off of B's flag to A's high half;
- gating by pin level and the choice of source;
- a set beating a same-cycle clear.

A long random phase then compares every read address and both flags against the behavioural model, cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADR_A_LO  = 0;
  localparam int ADR_A_HI  = 1;
  localparam int ADR_B_LO  = 2;
  localparam int ADR_B_HI  = 3;
  localparam int ADR_A_CTL = 4;
  localparam int ADR_B_CTL = 5;
  localparam int ADR_FLAGS = 6;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'd0,
    MODE_CNT16   = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } tmr_mode_e;

  // bit 4 source, bit 3 gate, bit 2 run, bits 1:0 mode
  typedef struct packed {
    logic      src_ext;
    logic      gate;
    logic      run;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_gate.sv
module tmr_gate (
  input  logic cyc_tick,
  input  logic ev,
  input  logic pin,
  input  logic src_ext,
  input  logic gate,
  input  logic run,
  output logic en
);
  logic tick;

  assign tick = src_ext ? ev : cyc_tick;
  assign en   = tick & run & (~gate | pin);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_mode_e     mode,
  input  logic          step_lo,
  input  logic          step_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q,
  output logic          wrap_main,
  output logic          wrap_split
);
  localparam logic [DW-1:0] ONES     = '1;
  localparam logic [DW-1:0] PRE_MASK = {{(DW-PRE_W){1'b0}}, {PRE_W{1'b1}}};

  logic [DW-1:0] lo_inc, hi_inc, lo_d, hi_d;
  logic          lo_full, hi_full, pre_carry, chain_go;

  assign lo_inc    = lo_q + 1'b1;
  assign hi_inc    = hi_q + 1'b1;
  assign lo_full   = (lo_q == ONES);
  assign hi_full   = (hi_q == ONES);
  assign pre_carry = (lo_inc > PRE_MASK);
  assign chain_go  = step_lo & ~wr_lo & ~wr_hi;

  always_comb begin
    lo_d       = lo_q;
    hi_d       = hi_q;
    wrap_main  = 1'b0;
    wrap_split = 1'b0;
    case (mode)
      MODE_PRE13: begin
        if (chain_go) begin
          if (pre_carry) begin
            lo_d      = lo_inc & PRE_MASK;
            hi_d      = hi_inc;
            wrap_main = hi_full;
          end else begin
            lo_d = lo_inc;
          end
        end
      end
      MODE_CNT16: begin
        if (chain_go) begin
          lo_d = lo_inc;
          if (lo_full) begin
            hi_d      = hi_inc;
            wrap_main = hi_full;
          end
        end
      end
      MODE_RELOAD8: begin
        if (chain_go) begin
          if (lo_full) begin
            lo_d      = hi_q;
            wrap_main = 1'b1;
          end else begin
            lo_d = lo_inc;
          end
        end
      end
      MODE_SPLIT: begin
        if (SPLIT_OK) begin
          if (step_lo && !wr_lo) begin
            lo_d      = lo_inc;
            wrap_main = lo_full;
          end
          if (step_hi && !wr_hi) begin
            hi_d       = hi_inc;
            wrap_split = hi_full;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/mcu_timer_pair.sv
module mcu_timer_pair
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_tick,
  input  logic          ev_a,
  input  logic          ev_b,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          ack_a,
  input  logic          ack_b,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  output logic          ovf_a,
  output logic          ovf_b
);
  localparam int NUM_TMR = 2;

  tmr_ctl_t             ctl_a, ctl_b;
  logic [DW-1:0]        lo_q [NUM_TMR];
  logic [DW-1:0]        hi_q [NUM_TMR];
  logic [NUM_TMR-1:0]   en, wrap_main, wrap_split, flag_set, flag_q, ack_vec, ev_vec, pin_vec;
  logic                 flag_wr;

  assign ack_vec = {ack_b, ack_a};
  assign ev_vec  = {ev_b, ev_a};
  assign pin_vec = {pin_b, pin_a};
  assign flag_wr = bus_wr && (int'(bus_waddr) == ADR_FLAGS);

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= '0;
      ctl_b <= '0;
    end else if (bus_wr) begin
      if (int'(bus_waddr) == ADR_A_CTL) ctl_a <= tmr_ctl_t'(bus_wdata[CTL_W-1:0]);
      if (int'(bus_waddr) == ADR_B_CTL) ctl_b <= tmr_ctl_t'(bus_wdata[CTL_W-1:0]);
    end
  end

  // A's split high half reports through B's flag
  assign flag_set[0] = wrap_main[0];
  assign flag_set[1] = (ctl_a.mode == MODE_SPLIT) ? wrap_split[0]
                                                   : (wrap_main[1] | wrap_split[1]);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam bit IS_A = (i == 0);
    tmr_ctl_t c;
    logic     wr_lo, wr_hi, hi_step;

    assign c       = IS_A ? ctl_a : ctl_b;
    assign wr_lo   = bus_wr && (int'(bus_waddr) == 2 * i);
    assign wr_hi   = bus_wr && (int'(bus_waddr) == 2 * i + 1);
    assign hi_step = IS_A ? (cyc_tick & ctl_b.run) : 1'b0;

    tmr_gate u_gate (
      .cyc_tick (cyc_tick),
      .ev       (ev_vec[i]),
      .pin      (pin_vec[i]),
      .src_ext  (c.src_ext),
      .gate     (c.gate),
      .run      (c.run),
      .en       (en[i])
    );

    tmr_chain #(
      .DW       (DW),
      .PRE_W    (PRE_W),
      .SPLIT_OK (IS_A)
    ) u_chain (
      .clk        (clk),
      .rst        (rst),
      .mode       (c.mode),
      .step_lo    (en[i]),
      .step_hi    (hi_step),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .wdata      (bus_wdata),
      .lo_q       (lo_q[i]),
      .hi_q       (hi_q[i]),
      .wrap_main  (wrap_main[i]),
      .wrap_split (wrap_split[i])
    );

    tmr_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (flag_set[i]),
      .clr_i  (ack_vec[i] | (flag_wr & bus_wdata[i])),
      .flag_q (flag_q[i])
    );
  end

  assign ovf_a = flag_q[0];
  assign ovf_b = flag_q[1];

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_raddr))
      ADR_A_LO:  bus_rdata = lo_q[0];
      ADR_A_HI:  bus_rdata = hi_q[0];
      ADR_B_LO:  bus_rdata = lo_q[1];
      ADR_B_HI:  bus_rdata = hi_q[1];
      ADR_A_CTL: bus_rdata[CTL_W-1:0] = ctl_a;
      ADR_B_CTL: bus_rdata[CTL_W-1:0] = ctl_b;
      ADR_FLAGS: bus_rdata[NUM_TMR-1:0] = flag_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks
  import tmr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [2:0] bus_waddr,
  input logic [7:0] bus_wdata,
  input logic       ack_a,
  input logic       ovf_a,
  input logic       ovf_b,
  input logic [7:0] a_lo,
  input logic [7:0] a_hi,
  input logic [7:0] b_lo,
  input logic [7:0] b_hi,
  input tmr_ctl_t   ctl_a,
  input tmr_ctl_t   ctl_b,
  input logic       en_a
);
  logic wr_a_cnt, wr_b_cnt, clr_a_sw;

  assign wr_a_cnt = bus_wr && (bus_waddr == 3'd0 || bus_waddr == 3'd1);
  assign wr_b_cnt = bus_wr && (bus_waddr == 3'd2 || bus_waddr == 3'd3);
  assign clr_a_sw = bus_wr && (bus_waddr == 3'd6) && bus_wdata[0];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (a_lo == 8'd0 && a_hi == 8'd0 && b_lo == 8'd0 && b_hi == 8'd0 &&
             !ovf_a && !ovf_b && ctl_a == '0 && ctl_b == '0));

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_a.run && ctl_a.mode != MODE_SPLIT && !wr_a_cnt) |=> ($stable(a_lo) && $stable(a_hi)));

  assert_wrap16_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (en_a && ctl_a.mode == MODE_CNT16 && a_lo == 8'hFF && a_hi == 8'hFF && !wr_a_cnt) |=> ovf_a);

  assert_reload_from_high_R6: assert property (@(posedge clk) disable iff (rst)
    (en_a && ctl_a.mode == MODE_RELOAD8 && a_lo == 8'hFF && !wr_a_cnt) |=> (a_lo == $past(a_hi)));

  assert_b_split_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_b.mode == MODE_SPLIT && !wr_b_cnt) |=> ($stable(b_lo) && $stable(b_hi)));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_waddr == 3'd0) |=> (a_lo == $past(bus_wdata)));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_a && !ack_a && !clr_a_sw) |=> ovf_a);
endmodule

bind mcu_timer_pair tmr_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_waddr (bus_waddr),
  .bus_wdata (bus_wdata),
  .ack_a     (ack_a),
  .ovf_a     (ovf_a),
  .ovf_b     (ovf_b),
  .a_lo      (lo_q[0]),
  .a_hi      (hi_q[0]),
  .b_lo      (lo_q[1]),
  .b_hi      (hi_q[1]),
  .ctl_a     (ctl_a),
  .ctl_b     (ctl_b),
  .en_a      (en[0])
);

// File: tb/test_mcu_timer_pair.sv
module test_mcu_timer_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_tick = 1'b0, ev_a = 1'b0, ev_b = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_waddr = 3'd0, bus_raddr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  wire  [7:0] bus_rdata;
  wire        ovf_a, ovf_b;

  always #10 clk = ~clk;

  mcu_timer_pair i_mcu_timer_pair (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ev_a(ev_a), .ev_b(ev_b),
    .pin_a(pin_a), .pin_b(pin_b), .ack_a(ack_a), .ack_b(ack_b),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  int    total = 0, bad = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_lo[2], m_hi[2], m_ctl[2], m_flg[2];
  int md_en[2], md_wlo[2], md_whi[2], md_wrap[2], md_set[2], md_clr[2];
  int md_wa, md_wd, md_n, md_mode, md_split, md_tick;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_ctl[i] = 0; m_flg[i] = 0;
      end
    end else begin
      md_wa = bus_wr ? int'(bus_waddr) : -1;
      md_wd = int'(bus_wdata);
      md_split = 0;
      for (int i = 0; i < 2; i++) begin
        md_tick = ((m_ctl[i] & 16) != 0) ? (i == 0 ? ev_a : ev_b) : cyc_tick;
        md_en[i] = (md_tick != 0) && ((m_ctl[i] & 4) != 0) &&
                   (((m_ctl[i] & 8) == 0) || ((i == 0 ? pin_a : pin_b) == 1'b1));
        md_wlo[i] = (md_wa == 2 * i);
        md_whi[i] = (md_wa == 2 * i + 1);
        md_wrap[i] = 0;
      end
      for (int i = 0; i < 2; i++) begin
        md_mode = m_ctl[i] % 4;
        if (md_mode == 3) begin
          if (md_wlo[i] != 0) m_lo[i] = md_wd;
          else if (i == 0 && md_en[0] != 0) begin
            if (m_lo[0] == 255) md_wrap[0] = 1;
            m_lo[0] = (m_lo[0] + 1) % 256;
          end
          if (md_whi[i] != 0) m_hi[i] = md_wd;
          else if (i == 0 && cyc_tick && (m_ctl[1] & 4) != 0) begin
            if (m_hi[0] == 255) md_split = 1;
            m_hi[0] = (m_hi[0] + 1) % 256;
          end
        end else if (md_wlo[i] != 0 || md_whi[i] != 0) begin
          if (md_wlo[i] != 0) m_lo[i] = md_wd;
          if (md_whi[i] != 0) m_hi[i] = md_wd;
        end else if (md_en[i] != 0) begin
          if (md_mode == 0) begin
            md_n = (m_lo[i] + 1) % 256;
            if (md_n > 31) begin
              m_lo[i] = md_n % 32;
              if (m_hi[i] == 255) md_wrap[i] = 1;
              m_hi[i] = (m_hi[i] + 1) % 256;
            end else m_lo[i] = md_n;
          end else if (md_mode == 1) begin
            if (m_lo[i] == 255) begin
              m_lo[i] = 0;
              if (m_hi[i] == 255) md_wrap[i] = 1;
              m_hi[i] = (m_hi[i] + 1) % 256;
            end else m_lo[i] = m_lo[i] + 1;
          end else begin
            if (m_lo[i] == 255) begin
              m_lo[i] = m_hi[i];
              md_wrap[i] = 1;
            end else m_lo[i] = m_lo[i] + 1;
          end
        end
      end
      md_set[0] = md_wrap[0];
      md_set[1] = (m_ctl[0] % 4 == 3) ? md_split : md_wrap[1];
      md_clr[0] = ack_a || (md_wa == 6 && (md_wd & 1) != 0);
      md_clr[1] = ack_b || (md_wa == 6 && (md_wd & 2) != 0);
      for (int i = 0; i < 2; i++) begin
        if (md_set[i] != 0) m_flg[i] = 1;
        else if (md_clr[i] != 0) m_flg[i] = 0;
      end
      if (md_wa == 4) m_ctl[0] = md_wd % 32;
      if (md_wa == 5) m_ctl[1] = md_wd % 32;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_lo[0];
      1: return m_hi[0];
      2: return m_lo[1];
      3: return m_hi[1];
      4: return m_ctl[0];
      5: return m_ctl[1];
      6: return m_flg[1] * 2 + m_flg[0];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model comparison on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    chk(cur_req, int'(bus_rdata), exp_rd(int'(bus_raddr)), "model rdata");
    chk(cur_req, int'(ovf_a), m_flg[0], "model ovf_a");
    chk(cur_req, int'(ovf_b), m_flg[1], "model ovf_b");
  end

  task automatic drv(bit w, int a, int d, bit t, bit ea, bit eb, bit aa, bit ab);
    @(negedge clk);
    bus_wr = w; bus_waddr = 3'(a); bus_wdata = 8'(d);
    cyc_tick = t; ev_a = ea; ev_b = eb; ack_a = aa; ack_b = ab;
  endtask

  task automatic wr(int a, int d);
    drv(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic stp(bit t, bit ea, bit eb);
    drv(0, 0, 0, t, ea, eb, 0, 0);
  endtask

  task automatic rd(string req, int a, int exp);
    drv(0, 0, 0, 0, 0, 0, 0, 0);
    bus_raddr = 3'(a);
    #1;
    chk(req, int'(bus_rdata), exp, $sformatf("reg%0d", a));
  endtask

  task automatic fl(string req, int ea_exp, int eb_exp);
    drv(0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk(req, int'(ovf_a), ea_exp, "ovf_a");
    chk(req, int'(ovf_b), eb_exp, "ovf_b");
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    total++; bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, mode 0 in control
    cur_req = "R1";
    for (int a = 0; a < 7; a++) rd("R1", a, 0);
    fl("R1", 0, 0);

    // R2: run bit, source select and gating
    cur_req = "R2";
    wr(0, 8'h05);
    repeat (5) stp(1, 1, 0);
    rd("R2", 0, 8'h05);
    wr(4, 8'h05);
    repeat (3) stp(1, 0, 0);
    rd("R2", 0, 8'h08);
    wr(4, 8'h15);
    repeat (4) stp(1, 0, 0);
    rd("R2", 0, 8'h08);
    repeat (2) stp(0, 1, 0);
    rd("R2", 0, 8'h0A);
    wr(4, 8'h0D);
    pin_a = 1'b0;
    repeat (3) stp(1, 0, 0);
    rd("R2", 0, 8'h0A);
    pin_a = 1'b1;
    repeat (3) stp(1, 0, 0);
    rd("R2", 0, 8'h0D);
    pin_a = 1'b0;

    // R3/R4: 13-bit mode
    cur_req = "R3";
    wr(4, 8'h04); wr(0, 8'h1E); wr(1, 8'hFF);
    stp(1, 0, 0);
    rd("R3", 0, 8'h1F);
    fl("R4", 0, 0);
    stp(1, 0, 0);
    rd("R3", 0, 8'h00);
    rd("R4", 1, 8'h00);
    fl("R4", 1, 0);
    wr(6, 8'h01);
    fl("R11", 0, 0);
    wr(0, 8'h25);
    stp(1, 0, 0);
    rd("R3", 0, 8'h06);
    rd("R3", 1, 8'h01);

    // R5: 16-bit mode
    cur_req = "R5";
    wr(4, 8'h05); wr(0, 8'hFE); wr(1, 8'hFF);
    stp(1, 0, 0);
    rd("R5", 0, 8'hFF);
    fl("R5", 0, 0);
    stp(1, 0, 0);
    rd("R5", 0, 8'h00);
    rd("R5", 1, 8'h00);
    fl("R5", 1, 0);
    drv(0, 0, 0, 0, 0, 0, 1, 0);
    fl("R11", 0, 0);
    wr(0, 8'hFF); wr(1, 8'h12);
    stp(1, 0, 0);
    rd("R5", 0, 8'h00);
    rd("R5", 1, 8'h13);
    fl("R5", 0, 0);

    // R6: reload mode
    cur_req = "R6";
    wr(4, 8'h06); wr(1, 8'hF0); wr(0, 8'hFE);
    stp(1, 0, 0);
    rd("R6", 0, 8'hFF);
    stp(1, 0, 0);
    rd("R6", 0, 8'hF0);
    rd("R6", 1, 8'hF0);
    fl("R6", 1, 0);
    stp(1, 0, 0);
    rd("R6", 0, 8'hF1);
    wr(6, 8'h03);

    // R7/R8: split mode
    cur_req = "R7";
    wr(5, 8'h14); wr(4, 8'h07); wr(0, 8'hFF); wr(1, 8'hFE);
    fl("R7", 0, 0);
    stp(1, 0, 0);
    rd("R7", 0, 8'h00);
    rd("R8", 1, 8'hFF);
    fl("R7", 1, 0);
    stp(1, 0, 0);
    rd("R8", 1, 8'h00);
    rd("R7", 0, 8'h01);
    fl("R8", 1, 1);
    cur_req = "R8";
    wr(5, 8'h10);
    repeat (2) stp(1, 0, 0);
    rd("R8", 1, 8'h00);
    rd("R7", 0, 8'h03);
    wr(6, 8'h03); wr(5, 8'h16); wr(2, 8'hFF);
    stp(0, 0, 1);
    rd("R8", 2, 8'h00);
    fl("R8", 0, 0);

    // R9: B in mode 3 holds
    cur_req = "R9";
    wr(4, 8'h05); wr(5, 8'h07); wr(2, 8'h33);
    repeat (3) stp(1, 0, 1);
    rd("R9", 2, 8'h33);
    rd("R9", 3, 8'h00);

    // R10: write beats count
    cur_req = "R10";
    wr(5, 8'h00); wr(4, 8'h05);
    drv(1, 0, 8'h40, 1, 0, 0, 0, 0);
    rd("R10", 0, 8'h40);
    wr(4, 8'h06); wr(0, 8'hFF); wr(6, 8'h03);
    drv(1, 1, 8'h77, 1, 0, 0, 0, 0);
    rd("R10", 0, 8'hFF);
    rd("R10", 1, 8'h77);
    fl("R10", 0, 0);
    stp(1, 0, 0);
    rd("R6", 0, 8'h77);

    // R11: set wins over same-cycle clear
    cur_req = "R11";
    wr(4, 8'h05); wr(0, 8'hFF); wr(1, 8'hFF); wr(6, 8'h03);
    fl("R11", 0, 0);
    drv(0, 0, 0, 1, 0, 0, 1, 0);
    fl("R11", 1, 0);

    // R12: register map corners
    cur_req = "R12";
    rd("R12", 7, 0);
    wr(7, 8'hAB);
    rd("R12", 7, 0);
    wr(4, 8'hFF);
    rd("R12", 4, 8'h1F);
    wr(5, 8'hE2);
    rd("R12", 5, 8'h02);
    wr(4, 8'h00); wr(5, 8'h00);

    // mixed random traffic against the model
    cur_req = "R10";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      cyc_tick  = 1'($urandom_range(0, 1));
      ev_a      = 1'($urandom_range(0, 1));
      ev_b      = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) pin_a = ~pin_a;
      if ($urandom_range(0, 3) == 0) pin_b = ~pin_b;
      ack_a     = ($urandom_range(0, 15) == 0);
      ack_b     = ($urandom_range(0, 15) == 0);
      bus_wr    = ($urandom_range(0, 5) == 0);
      bus_waddr = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom_range(0, 255));
      bus_raddr = 3'($urandom_range(0, 7));
    end

    // R1: reset after activity
    cur_req = "R1";
    drv(0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 7; a++) rd("R1", a, 0);
    fl("R1", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule